// File: doc/BRIEF.md
# Two-Bank Byte-Addressable Memory

This block is a byte-addressable store made of two byte-wide banks: one holds every even byte address, the other every odd one. A requester sees a single 16-bit data path, a byte/word size select and a 20-bit byte address. Multi-byte values are kept little-endian, with the less significant byte at the lower address. Because each bank has its own enable, any single byte and any word at an even address finish in one bank cycle. A word at an odd address straddles two rows, so it is carried out as two back-to-back bank accesses. The `busy` output is high during the extra cycle.

Requests enter on a valid/ready channel, and every request, read or write, produces one response on a valid/ready channel. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low while the second half of a split word is running. It is also low while a response is waiting and `rsp_ready` is low. A waiting response keeps `rsp_valid` and `rsp_rdata` unchanged until it is taken. With `rsp_ready` held high, one aligned or byte request can be accepted every cycle. The physical storage holds 2^STORE_W bytes, and byte addresses that agree in their low STORE_W bits reach the same byte.

Top module: `banked_byte_mem`

## Requirements
- R1: A word write at byte address N stores req_wdata[7:0] at N and req_wdata[15:8] at N+1. A word read at N returns the byte at N+1 in bits 15:8 and the byte at N in bits 7:0.
- R2: A byte access at an even address carries its byte on data bits 7:0, and one at an odd address carries it on bits 15:8. In a byte read response the unused lane reads as zero.
- R3: A byte write changes only its own byte. The byte that shares its word row in the other bank keeps its value.
- R4: A byte request or an even-address word request gets its response on the first rising edge after acceptance, with `busy` low. `req_ready` stays high meanwhile when `rsp_ready` is high, so such requests can be accepted back to back.
- R5: A word request at an odd address N first accesses N in the odd bank and then N+1 in the even bank. `busy` is high for exactly the one cycle after acceptance, `req_ready` is low during that cycle, and the response follows on the second rising edge after acceptance.
- R6: A word access at byte address FFFFFh places its high byte at address 00000h.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold their values and `req_ready` is low.
- R8: A write request also produces a response, and its `rsp_rdata` is zero.
- R9: After reset, `rsp_valid` and `busy` are low and `req_ready` is high.
- R10: Byte addresses that agree in their low STORE_W bits (default 12) select the same stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = single byte |
| req_addr | input | ADDR_W (20) | Byte address |
| req_wdata | input | 16 | Write data, lanes as in R1 and R2 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response can be taken |
| rsp_rdata | output | 16 | Read data, zero for writes |
| busy | output | 1 | Second half of a split word in progress |

## Verification
The response to a byte or even-address word is due one rising edge after the edge that accepts the request. The response to an odd-address word is due two edges after acceptance, and `busy` is high on the edge between. The bench drives and samples on falling edges and counts falling edges from acceptance until `rsp_valid` appears, so both data and latency are checked at the exact cycle the requirements give. It also checks `busy` at the first falling edge after acceptance. Back-to-back acceptance and the stall under `rsp_ready` low are checked one falling edge at a time.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

  localparam int unsigned LANE_W = 8;
  localparam int unsigned PORT_W = 2 * LANE_W;

  // Which lanes of the bank outputs a response carries.
  typedef enum logic [2:0] {
    RK_WRITE        = 3'd0,
    RK_BYTE_EVEN    = 3'd1,
    RK_BYTE_ODD     = 3'd2,
    RK_WORD_ALIGNED = 3'd3,
    RK_WORD_SPLIT   = 3'd4
  } rsp_kind_e;

endpackage

// File: rtl/bbm_bank_ram.sv
module bbm_bank_ram #(
  parameter int unsigned ROW_W       = 19,
  parameter int unsigned STORE_ROW_W = 11,
  parameter int unsigned BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [BYTE_W-1:0] wd,
  output logic [BYTE_W-1:0] q
);

  localparam int unsigned DEPTH = 1 << STORE_ROW_W;

  logic [BYTE_W-1:0]      mem [DEPTH];
  logic [STORE_ROW_W-1:0] idx;

  // Rows above the implemented depth fold onto the stored ones.
  generate
    if (ROW_W > STORE_ROW_W) begin : g_fold
      logic [ROW_W-STORE_ROW_W-1:0] unused_row_hi;
      assign unused_row_hi = row[ROW_W-1:STORE_ROW_W];
      assign idx = row[STORE_ROW_W-1:0];
    end else begin : g_full
      assign idx = row[STORE_ROW_W-1:0];
    end
  endgenerate

  // Read register changes only on an enabled read, so it holds otherwise.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[idx] <= wd;
      else    q        <= mem[idx];
    end
  end

endmodule

// File: rtl/bbm_lane_steer.sv
module bbm_lane_steer #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned ROW_W  = ADDR_W - 1
) (
  input  logic                       req_write,
  input  logic                       req_word,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [bbm_pkg::PORT_W-1:0] req_wdata,
  input  logic                       accept,
  input  logic                       split_act,
  input  logic                       split_write,
  input  logic [ROW_W-1:0]           split_row,
  input  logic [bbm_pkg::LANE_W-1:0] split_wbyte,
  output logic                       ev_en,
  output logic                       ev_we,
  output logic [ROW_W-1:0]           ev_row,
  output logic [bbm_pkg::LANE_W-1:0] ev_wd,
  output logic                       od_en,
  output logic                       od_we,
  output logic [ROW_W-1:0]           od_row,
  output logic [bbm_pkg::LANE_W-1:0] od_wd,
  output logic [ROW_W-1:0]           nxt_row
);
  import bbm_pkg::*;

  logic [ROW_W-1:0]  req_row;
  logic [LANE_W-1:0] lo_byte;
  logic [LANE_W-1:0] hi_byte;
  logic              odd_lane;

  assign req_row  = req_addr[ADDR_W-1:1];
  assign nxt_row  = req_row + 1'b1;   // wraps to row 0 past the top
  assign lo_byte  = req_wdata[LANE_W-1:0];
  assign hi_byte  = req_wdata[PORT_W-1:LANE_W];
  assign odd_lane = req_addr[0];

  always_comb begin
    ev_en  = 1'b0;
    ev_we  = 1'b0;
    ev_row = req_row;
    ev_wd  = lo_byte;
    od_en  = 1'b0;
    od_we  = 1'b0;
    od_row = req_row;
    od_wd  = hi_byte;
    if (split_act) begin
      // second half of an odd-address word: next row, even bank
      ev_en  = 1'b1;
      ev_we  = split_write;
      ev_row = split_row;
      ev_wd  = split_wbyte;
    end else if (accept) begin
      if (req_word && !odd_lane) begin
        ev_en = 1'b1;
        ev_we = req_write;
        od_en = 1'b1;
        od_we = req_write;
      end else if (req_word) begin
        // first half: low byte goes to the odd bank of this row
        od_en = 1'b1;
        od_we = req_write;
        od_wd = lo_byte;
      end else if (odd_lane) begin
        od_en = 1'b1;
        od_we = req_write;
      end else begin
        ev_en = 1'b1;
        ev_we = req_write;
      end
    end
  end

endmodule

// File: rtl/bbm_xact_ctrl.sv
module bbm_xact_ctrl #(
  parameter int unsigned ROW_W = 19
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic                       req_word,
  input  logic                       req_lane,
  input  logic                       rsp_ready,
  input  logic [ROW_W-1:0]           nxt_row,
  input  logic [bbm_pkg::LANE_W-1:0] hi_byte,
  output logic                       req_ready,
  output logic                       accept,
  output logic                       split_act,
  output logic                       split_write,
  output logic [ROW_W-1:0]           split_row,
  output logic [bbm_pkg::LANE_W-1:0] split_wbyte,
  output logic                       rsp_valid,
  output bbm_pkg::rsp_kind_e         rkind
);
  import bbm_pkg::*;

  logic      is_split;
  rsp_kind_e kind_now;

  assign req_ready = !split_act && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;
  assign is_split  = req_word && req_lane;

  always_comb begin
    if (req_write)     kind_now = RK_WRITE;
    else if (req_word) kind_now = RK_WORD_ALIGNED;
    else if (req_lane) kind_now = RK_BYTE_ODD;
    else               kind_now = RK_BYTE_EVEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      split_act <= 1'b0;
      rsp_valid <= 1'b0;
      rkind     <= RK_WRITE;
    end else if (split_act) begin
      split_act <= 1'b0;
      rsp_valid <= 1'b1;
      rkind     <= split_write ? RK_WRITE : RK_WORD_SPLIT;
    end else if (accept) begin
      if (is_split) begin
        split_act <= 1'b1;
        rsp_valid <= 1'b0;
      end else begin
        rsp_valid <= 1'b1;
        rkind     <= kind_now;
      end
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // Context for the second half; no reset needed, qualified by split_act.
  always_ff @(posedge clk) begin
    if (accept && is_split) begin
      split_write <= req_write;
      split_row   <= nxt_row;
      split_wbyte <= hi_byte;
    end
  end

endmodule

// File: rtl/banked_byte_mem.sv
module banked_byte_mem #(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned STORE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_rdata,
  output logic              busy
);
  import bbm_pkg::*;

  localparam int unsigned ROW_W       = ADDR_W - 1;
  localparam int unsigned STORE_ROW_W = STORE_W - 1;

  logic              accept;
  logic              split_act;
  logic              split_write;
  logic [ROW_W-1:0]  split_row;
  logic [LANE_W-1:0] split_wbyte;
  logic [ROW_W-1:0]  nxt_row;
  rsp_kind_e         rkind;

  logic              ev_en, ev_we, od_en, od_we;
  logic [ROW_W-1:0]  ev_row, od_row;
  logic [LANE_W-1:0] ev_wd, od_wd, ev_q, od_q;

  bbm_lane_steer #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_steer (
    .req_write  (req_write),
    .req_word   (req_word),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .accept     (accept),
    .split_act  (split_act),
    .split_write(split_write),
    .split_row  (split_row),
    .split_wbyte(split_wbyte),
    .ev_en      (ev_en),
    .ev_we      (ev_we),
    .ev_row     (ev_row),
    .ev_wd      (ev_wd),
    .od_en      (od_en),
    .od_we      (od_we),
    .od_row     (od_row),
    .od_wd      (od_wd),
    .nxt_row    (nxt_row)
  );

  bbm_xact_ctrl #(.ROW_W(ROW_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_word   (req_word),
    .req_lane   (req_addr[0]),
    .rsp_ready  (rsp_ready),
    .nxt_row    (nxt_row),
    .hi_byte    (req_wdata[PORT_W-1:LANE_W]),
    .req_ready  (req_ready),
    .accept     (accept),
    .split_act  (split_act),
    .split_write(split_write),
    .split_row  (split_row),
    .split_wbyte(split_wbyte),
    .rsp_valid  (rsp_valid),
    .rkind      (rkind)
  );

  bbm_bank_ram #(.ROW_W(ROW_W), .STORE_ROW_W(STORE_ROW_W), .BYTE_W(LANE_W)) u_even (
    .clk(clk), .en(ev_en), .we(ev_we), .row(ev_row), .wd(ev_wd), .q(ev_q)
  );

  bbm_bank_ram #(.ROW_W(ROW_W), .STORE_ROW_W(STORE_ROW_W), .BYTE_W(LANE_W)) u_odd (
    .clk(clk), .en(od_en), .we(od_we), .row(od_row), .wd(od_wd), .q(od_q)
  );

  assign busy = split_act;

  always_comb begin
    case (rkind)
      RK_BYTE_EVEN:    rsp_rdata = {{LANE_W{1'b0}}, ev_q};
      RK_BYTE_ODD:     rsp_rdata = {od_q, {LANE_W{1'b0}}};
      RK_WORD_ALIGNED: rsp_rdata = {od_q, ev_q};
      RK_WORD_SPLIT:   rsp_rdata = {ev_q, od_q};
      default:         rsp_rdata = '0;
    endcase
  end

endmodule

// File: rtl/bbm_chk.sv
module bbm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_word,
  input logic        req_lane,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_rdata,
  input logic        busy,
  input logic        ev_en,
  input logic        od_en
);

  logic acc;
  assign acc = req_valid && req_ready;

  // R4: single-cycle response for bytes and even-address words
  a_r4_single_cycle_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !(req_word && req_lane) |=> rsp_valid && !busy);

  // R5: odd-address word enters the busy cycle
  a_r5_split_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_word && req_lane |=> busy && !rsp_valid);

  // R5: busy lasts one cycle and ends with the response
  a_r5_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy && rsp_valid);

  // R5: nothing is accepted while busy
  a_r5_busy_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R7: a stalled response holds
  a_r7_hold_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R7: no acceptance while a response is stalled
  a_r7_stall_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R3: a byte access enables exactly one bank
  a_r3_byte_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_word |-> $onehot({ev_en, od_en}));

endmodule

bind banked_byte_mem bbm_chk u_bbm_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_word (req_word),
  .req_lane (req_addr[0]),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata),
  .busy     (busy),
  .ev_en    (ev_en),
  .od_en    (od_en)
);

// File: tb/test_banked_byte_mem.sv
`timescale 1ns/1ps
module test_banked_byte_mem;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_word = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;
  logic        busy;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  banked_byte_mem i_banked_byte_mem (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .busy(busy)
  );

  // {req id(4), write(1), word(1), addr(20), wdata(16), expected rdata(16)}
  localparam int NV = 24;
  localparam logic [57:0] VEC [NV] = '{
    {4'd8,  1'b1, 1'b1, 20'h00100, 16'h1234, 16'h0000}, // R8 word write
    {4'd2,  1'b0, 1'b0, 20'h00100, 16'h0000, 16'h0034}, // R2 even lane
    {4'd2,  1'b0, 1'b0, 20'h00101, 16'h0000, 16'h1200}, // R2 odd lane
    {4'd1,  1'b0, 1'b1, 20'h00100, 16'h0000, 16'h1234}, // R1 little-endian
    {4'd8,  1'b1, 1'b0, 20'h00101, 16'hAB00, 16'h0000}, // R8 byte write odd
    {4'd3,  1'b0, 1'b1, 20'h00100, 16'h0000, 16'hAB34}, // R3 even kept
    {4'd8,  1'b1, 1'b0, 20'h00100, 16'h00CD, 16'h0000}, // R8 byte write even
    {4'd3,  1'b0, 1'b1, 20'h00100, 16'h0000, 16'hABCD}, // R3 odd kept
    {4'd5,  1'b1, 1'b1, 20'h00203, 16'h7B3D, 16'h0000}, // R5 split write
    {4'd5,  1'b0, 1'b0, 20'h00203, 16'h0000, 16'h3D00}, // R5 low byte at N
    {4'd5,  1'b0, 1'b0, 20'h00204, 16'h0000, 16'h007B}, // R5 high byte at N+1
    {4'd5,  1'b0, 1'b1, 20'h00203, 16'h0000, 16'h7B3D}, // R5 split read
    {4'd8,  1'b1, 1'b0, 20'h00202, 16'h0011, 16'h0000}, // R8
    {4'd8,  1'b1, 1'b0, 20'h00205, 16'h2200, 16'h0000}, // R8
    {4'd1,  1'b0, 1'b1, 20'h00202, 16'h0000, 16'h3D11}, // R1
    {4'd3,  1'b0, 1'b1, 20'h00204, 16'h0000, 16'h227B}, // R3 neighbour kept
    {4'd6,  1'b1, 1'b1, 20'hFFFFF, 16'h8A5F, 16'h0000}, // R6 wrap write
    {4'd6,  1'b0, 1'b0, 20'h00000, 16'h0000, 16'h008A}, // R6 high byte at 0
    {4'd6,  1'b0, 1'b0, 20'hFFFFF, 16'h0000, 16'h5F00}, // R6 low byte at top
    {4'd6,  1'b0, 1'b1, 20'hFFFFF, 16'h0000, 16'h8A5F}, // R6 wrap read
    {4'd10, 1'b0, 1'b0, 20'h01100, 16'h0000, 16'h00CD}, // R10 alias of 100h
    {4'd10, 1'b0, 1'b1, 20'h01202, 16'h0000, 16'h3D11}, // R10 alias of 202h
    {4'd8,  1'b1, 1'b1, 20'h00A10, 16'h9876, 16'h0000}, // R8
    {4'd1,  1'b0, 1'b1, 20'h00A10, 16'h0000, 16'h9876}  // R1
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One request with rsp_ready high; checks data, latency and busy.
  task automatic xact(input int rid, input bit wr, input bit wd,
                      input logic [19:0] a, input logic [15:0] d,
                      input logic [15:0] exp);
    int lat;
    int exp_lat;
    bit busy_at1;
    string tag;
    int guard;
    tag = $sformatf("R%0d", rid);
    exp_lat = (wd && a[0]) ? 2 : 1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = wd;
    req_addr = a; req_wdata = d; rsp_ready = 1'b1;
    guard = 0;
    while (!req_ready && guard < 20) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    busy_at1 = busy;
    while (!rsp_valid && lat < 6) begin @(negedge clk); lat++; end
    check(rsp_rdata == exp, tag, $sformatf("rdata @%05h", a), rsp_rdata, exp);
    // R4 / R5 latency
    check(lat == exp_lat, (exp_lat == 2) ? "R5" : "R4", "latency", lat, exp_lat);
    check(busy_at1 == (exp_lat == 2), (exp_lat == 2) ? "R5" : "R4",
          "busy after accept", busy_at1, exp_lat == 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(rsp_valid == 1'b0, "R9", "rsp_valid in reset", rsp_valid, 0);
    check(busy == 1'b0, "R9", "busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R9", "req_ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R9", "rsp_valid after reset", rsp_valid, 0);

    for (int i = 0; i < NV; i++) begin
      xact(int'(VEC[i][57:54]), VEC[i][53], VEC[i][52], VEC[i][51:32],
           VEC[i][31:16], VEC[i][15:0]);
    end

    // R4 back-to-back byte reads
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_word = 1'b0; req_addr = 20'h00100;
    check(req_ready == 1'b1, "R4", "ready first", req_ready, 1);
    @(negedge clk);
    check(rsp_valid && rsp_rdata == 16'h00CD, "R4", "first rsp", rsp_rdata, 16'h00CD);
    check(req_ready == 1'b1, "R4", "ready second", req_ready, 1);
    req_addr = 20'h00101;
    @(negedge clk);
    check(rsp_valid && rsp_rdata == 16'hAB00, "R4", "second rsp", rsp_rdata, 16'hAB00);
    req_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R4", "rsp drained", rsp_valid, 0);

    // R7 stalled response
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_word = 1'b1; req_addr = 20'h00202;
    @(negedge clk);
    req_addr = 20'h00100; // offered while stalled, must wait
    for (int k = 0; k < 3; k++) begin
      check(rsp_valid == 1'b1, "R7", "valid held", rsp_valid, 1);
      check(rsp_rdata == 16'h3D11, "R7", "data held", rsp_rdata, 16'h3D11);
      check(req_ready == 1'b0, "R7", "ready low", req_ready, 0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_rdata == 16'hABCD, "R7", "queued request served",
          rsp_rdata, 16'hABCD);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R7", "rsp drained", rsp_valid, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule